// File: doc/BRIEF.md
# USB Remote Wake-up Sequencer

This block lets a suspended full-speed USB device wake its host. Firmware arms a wake request by writing a register bit. The block then waits until the bus has been quiet for a minimum time. After that it asks the transceiver to drive a K state upstream for a programmable number of milliseconds. At the moment signaling starts, it records an interrupt flag and drops the suspend flag. When signaling ends, the wake request clears itself.

Separately, the block watches the decoded line for the host's end-of-resume pattern. That pattern is a host-driven K, followed by a long enough SE0, followed by J. When the pattern completes, a second interrupt flag is raised. Both flags are cleared by writing 1 to them, and each flag has its own enable. The interrupt output is the OR of the enabled flags.

All millisecond timing comes from a 1 kHz tick divided down from the clock by a parameter. The line state uses the encoding 2'b00 = SE0, 2'b01 = J, 2'b10 = K, 2'b11 = SE1. Register writes use a 2-bit address:

- Address 0, bit 0: wake request (write 1 to set).
- Address 1: resume length in ms.
- Address 2: flags, write 1 to clear. Bit 0 is the upstream-resume flag; bit 1 is the end-of-resume flag.
- Address 3: interrupt enables, with the same bit positions as address 2.

Top module: `usb_rwake_seq`

## Requirements
- R1: Writing 1 to bit 0 of address 0 while `suspended` is high arms a wake request. `wakeReq` reads 1 from the following cycle until resume signaling ends, and `driveK` stays low while the idle time is unmet.
- R2: Writing that bit while `suspended` is low is ignored. `wakeReq` stays 0 and `driveK` never rises.
- R3: The line counts as idle on an edge when `busIdle` is high and the line is J. Any other sample restarts the count. `driveK` rises on the first edge at which a request is pending and at least IDLE_MS*CLK_PER_MS consecutive idle edges have already passed.
- R4: `driveK` stays high for exactly D*CLK_PER_MS cycles, where D is address 1 (reset value RSM_MS_DEF, and 0 acts as 1). `wakeReq` falls together with `driveK`.
- R5: On the edge where `driveK` rises, `upRsmFlag` is set and `suspended` is cleared.
- R6: Outside own signaling, a K followed by at least 2*CLKS_PER_BIT consecutive SE0 samples and then a J sets `eoRsmFlag` on the J edge. A shorter SE0 leaves the flag clear.
- R7: Writing 1 to bit 0 or bit 1 of address 2 clears `upRsmFlag` or `eoRsmFlag` respectively. Writing 0 to either bit leaves that flag unchanged.
- R8: `irq` is high exactly when a flag is set and its enable bit (address 3, same positions) is 1.
- R9: A `suspendDet` pulse sets `suspended`.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busIdle | input | 1 | No bus activity seen |
| lineState | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| suspendDet | input | 1 | Pulse: device entered suspend |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| driveK | output | 1 | Request to drive K upstream |
| wakeReq | output | 1 | Wake request readback |
| suspended | output | 1 | Suspend status |
| upRsmFlag | output | 1 | Upstream resume sent flag |
| eoRsmFlag | output | 1 | End-of-resume seen flag |
| irq | output | 1 | OR of enabled flags |

## Verification
The assertions check the following on every cycle:
- a wake request only arms while the device is suspended;
- `driveK` never rises before the idle counter reports enough quiet time;
- signaling only stops when the ms counter reaches the programmed length;
- starting resume always sets the flag and drops suspend;
- the idle counter never passes its limit.

Only the bench scenarios can show the exact numbers. These are:
- the edge count from idle start to `driveK`, including restarts caused by line glitches;
- the exact signaling length for each programmed value, including zero;
- the boundary between an SE0 one sample too short and one just long enough;
- how flag clearing and enable masking behave at the interrupt output.

// File: rtl/usb_rwake_pkg.sv
package usb_rwake_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } lineState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restartDiv;  // zero the ms divider
    logic clrIdle;     // zero the idle ms counter
    logic startRsm;    // resume signaling begins this edge
    logic setEoRsm;    // end-of-resume pattern complete
  } dpStrobe_t;

  localparam logic [1:0] REG_WAKE = 2'd0;
  localparam logic [1:0] REG_DUR  = 2'd1;
  localparam logic [1:0] REG_FLAG = 2'd2;
  localparam logic [1:0] REG_IEN  = 2'd3;

endpackage

// File: rtl/rwake_dpath.sv
module rwake_dpath
  import usb_rwake_pkg::*;
#(
  parameter int CLK_PER_MS   = 48000,
  parameter int IDLE_MS      = 5,
  parameter int CLKS_PER_BIT = 4,
  parameter int DATA_W       = 8,
  parameter int RSM_MS_DEF   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              lineSe0,
  input  logic              suspendDet,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              idleMet,
  output logic              rsmDone,
  output logic              se0Long,
  output logic              suspended,
  output logic              upRsmFlag,
  output logic              eoRsmFlag,
  output logic              irq
);

  localparam int DIV_W   = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam int IDLE_W  = $clog2(IDLE_MS + 1);
  localparam int SE0_MIN = 2 * CLKS_PER_BIT;
  localparam int SE0_W   = $clog2(SE0_MIN + 1);

  logic [DIV_W-1:0]  divCnt;
  logic [IDLE_W-1:0] idleMs;
  logic [DATA_W-1:0] rsmMs;
  logic [DATA_W-1:0] durReg;
  logic [DATA_W-1:0] durEff;
  logic [SE0_W-1:0]  se0Cnt;
  logic [1:0]        ienReg;
  logic              msTick;

  assign msTick = (divCnt == DIV_W'(CLK_PER_MS - 1));

  always_ff @(posedge clk) begin
    if (!rstN)                               divCnt <= '0;
    else if (strobe.restartDiv || msTick)    divCnt <= '0;
    else                                     divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrIdle)                       idleMs <= '0;
    else if (msTick && idleMs < IDLE_W'(IDLE_MS))      idleMs <= idleMs + 1'b1;
  end
  assign idleMet = (idleMs >= IDLE_W'(IDLE_MS));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.startRsm) rsmMs <= '0;
    else if (msTick)              rsmMs <= rsmMs + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                             durReg <= DATA_W'(RSM_MS_DEF);
    else if (wrEn && wrAddr == REG_DUR)    durReg <= wrData;
  end
  assign durEff  = (durReg == '0) ? DATA_W'(1) : durReg;
  assign rsmDone = msTick && (rsmMs == durEff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || !lineSe0)                    se0Cnt <= '0;
    else if (se0Cnt < SE0_W'(SE0_MIN))        se0Cnt <= se0Cnt + 1'b1;
  end
  assign se0Long = (se0Cnt >= SE0_W'(SE0_MIN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      suspended <= 1'b0;
      upRsmFlag <= 1'b0;
      eoRsmFlag <= 1'b0;
      ienReg    <= 2'b00;
    end else begin
      if (strobe.startRsm)  suspended <= 1'b0;
      else if (suspendDet)  suspended <= 1'b1;

      if (strobe.startRsm)                                  upRsmFlag <= 1'b1;
      else if (wrEn && wrAddr == REG_FLAG && wrData[0])     upRsmFlag <= 1'b0;

      if (strobe.setEoRsm)                                  eoRsmFlag <= 1'b1;
      else if (wrEn && wrAddr == REG_FLAG && wrData[1])     eoRsmFlag <= 1'b0;

      if (wrEn && wrAddr == REG_IEN) ienReg <= wrData[1:0];
    end
  end

  assign irq = |({eoRsmFlag, upRsmFlag} & ienReg);

  AST_RSM_SIDE_EFFECTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startRsm |=> upRsmFlag && !suspended);  // R5
  AST_EOR_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEoRsm |=> eoRsmFlag);  // R6
  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    idleMs <= IDLE_W'(IDLE_MS));  // R3

endmodule

// File: rtl/rwake_ctrl.sv
module rwake_ctrl
  import usb_rwake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busIdle,
  input  lineState_t lineState,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic       wrBit0,
  input  logic       suspended,
  input  logic       idleMet,
  input  logic       rsmDone,
  input  logic       se0Long,
  output dpStrobe_t  strobe,
  output logic       driveK,
  output logic       wakeReq
);

  typedef enum logic [1:0] {WK_OFF, WK_ARMED, WK_DRIVE} wkState_t;
  typedef enum logic [1:0] {EOR_IDLE, EOR_HOSTK, EOR_SE0} eorState_t;

  wkState_t  wkState, wkNext;
  eorState_t eorState, eorNext;
  logic      lineIdle, wakeSet, driving, startRsm;

  assign lineIdle = busIdle && (lineState == LS_J);
  assign wakeSet  = wrEn && (wrAddr == REG_WAKE) && wrBit0 && suspended;
  assign driving  = (wkState == WK_DRIVE);
  assign startRsm = (wkState == WK_ARMED) && idleMet;

  always_comb begin
    wkNext = wkState;
    case (wkState)
      WK_OFF:   if (wakeSet)  wkNext = WK_ARMED;
      WK_ARMED: if (idleMet)  wkNext = WK_DRIVE;
      WK_DRIVE: if (rsmDone)  wkNext = WK_OFF;
      default:                wkNext = WK_OFF;
    endcase
  end

  always_comb begin
    eorNext = eorState;
    case (eorState)
      EOR_IDLE:  if (lineState == LS_K && !driving) eorNext = EOR_HOSTK;
      EOR_HOSTK: begin
        if (lineState == LS_SE0)                               eorNext = EOR_SE0;
        else if (lineState == LS_J || lineState == LS_SE1)     eorNext = EOR_IDLE;
      end
      EOR_SE0: begin
        if (lineState == LS_K)                                 eorNext = EOR_HOSTK;
        else if (lineState == LS_J || lineState == LS_SE1)     eorNext = EOR_IDLE;
      end
      default: eorNext = EOR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wkState  <= WK_OFF;
      eorState <= EOR_IDLE;
    end else begin
      wkState  <= wkNext;
      eorState <= eorNext;
    end
  end

  always_comb begin
    strobe.startRsm   = startRsm;
    strobe.restartDiv = startRsm || (!driving && !lineIdle);
    strobe.clrIdle    = startRsm || driving || !lineIdle;
    strobe.setEoRsm   = (eorState == EOR_SE0) && (lineState == LS_J) && se0Long;
  end

  assign driveK  = driving;
  assign wakeReq = (wkState != WK_OFF);

  AST_ARM_ONLY_SUSPENDED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReq) |-> $past(suspended));  // R1
  AST_DRIVE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveK) |-> $past(idleMet));  // R3
  AST_DRIVE_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveK) |-> $past(rsmDone) && !wakeReq);  // R4

endmodule

// File: rtl/usb_rwake_seq.sv
module usb_rwake_seq
  import usb_rwake_pkg::*;
#(
  parameter int CLK_PER_MS   = 48000,
  parameter int IDLE_MS      = 5,
  parameter int CLKS_PER_BIT = 4,
  parameter int DATA_W       = 8,
  parameter int RSM_MS_DEF   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busIdle,
  input  logic [1:0]        lineState,
  input  logic              suspendDet,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              driveK,
  output logic              wakeReq,
  output logic              suspended,
  output logic              upRsmFlag,
  output logic              eoRsmFlag,
  output logic              irq
);

  dpStrobe_t  strobe;
  lineState_t lineDec;
  logic       idleMet, rsmDone, se0Long;

  assign lineDec = lineState_t'(lineState);

  rwake_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busIdle   (busIdle),
    .lineState (lineDec),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrBit0    (wrData[0]),
    .suspended (suspended),
    .idleMet   (idleMet),
    .rsmDone   (rsmDone),
    .se0Long   (se0Long),
    .strobe    (strobe),
    .driveK    (driveK),
    .wakeReq   (wakeReq)
  );

  rwake_dpath #(
    .CLK_PER_MS   (CLK_PER_MS),
    .IDLE_MS      (IDLE_MS),
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .DATA_W       (DATA_W),
    .RSM_MS_DEF   (RSM_MS_DEF)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .lineSe0    (lineDec == LS_SE0),
    .suspendDet (suspendDet),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .idleMet    (idleMet),
    .rsmDone    (rsmDone),
    .se0Long    (se0Long),
    .suspended  (suspended),
    .upRsmFlag  (upRsmFlag),
    .eoRsmFlag  (eoRsmFlag),
    .irq        (irq)
  );

endmodule

// File: tb/tb_usb_rwake_seq.sv
module tb_usb_rwake_seq;

  localparam int CPM    = 10;
  localparam int IDLEMS = 5;
  localparam int CPB    = 3;
  localparam int DEFMS  = 2;
  localparam int NIDLE  = IDLEMS * CPM;
  localparam int SE0MIN = 2 * CPB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busIdle = 1'b0;
  logic [1:0] lineState = 2'b10;
  logic suspendDet = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic driveK, wakeReq, suspended, upRsmFlag, eoRsmFlag, irq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_rwake_seq #(
    .CLK_PER_MS(CPM), .IDLE_MS(IDLEMS), .CLKS_PER_BIT(CPB),
    .DATA_W(8), .RSM_MS_DEF(DEFMS)
  ) dut (
    .clk(clk), .rstN(rstN), .busIdle(busIdle), .lineState(lineState),
    .suspendDet(suspendDet), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .driveK(driveK), .wakeReq(wakeReq), .suspended(suspended),
    .upRsmFlag(upRsmFlag), .eoRsmFlag(eoRsmFlag), .irq(irq)
  );

  function automatic int expLen(int dur);
    return ((dur == 0) ? 1 : dur) * CPM;
  endfunction

  function automatic bit expEor(int se0Len);
    return se0Len >= SE0MIN;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0; wrData = 8'd0;
  endtask

  task automatic setLine(input logic idle, input logic [1:0] ls);
    busIdle = idle; lineState = ls;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step(); step(); step();
    rstN = 1'b1;
    step();
    // R10 reset state
    chk({driveK, wakeReq, suspended, upRsmFlag, eoRsmFlag, irq} == 6'b0, "R10",
        {driveK, wakeReq, suspended, upRsmFlag, eoRsmFlag, irq}, 0);

    // R2 wake while not suspended is ignored
    setLine(1'b1, 2'b01);
    wr(2'd0, 8'h01);
    chk(wakeReq == 1'b0, "R2", wakeReq, 0);
    begin
      int seen = 0;
      repeat (NIDLE + 5) begin step(); if (driveK) seen++; end
      chk(seen == 0, "R2", seen, 0);
    end

    wr(2'd3, 8'h03);
    // R9 suspend detect
    suspendDet = 1'b1; step(); suspendDet = 1'b0;
    chk(suspended == 1'b1, "R9", suspended, 1);

    // R3 idle already met: drive starts the edge after the write edge
    wr(2'd0, 8'h01);
    chk(wakeReq && !driveK, "R1", {wakeReq, driveK}, 2);
    step();
    chk(driveK == 1'b1, "R3", driveK, 1);
    chk(upRsmFlag && !suspended, "R5", {upRsmFlag, suspended}, 2);
    chk(irq == 1'b1, "R8", irq, 1);
    setLine(1'b0, 2'b10);
    begin
      int h = 0;
      while (driveK && h < 1000) begin step(); h++; end
      chk(h == expLen(DEFMS), "R4", h, expLen(DEFMS));
    end
    chk(wakeReq == 1'b0, "R4", wakeReq, 0);

    // R6 end of resume with exact minimum SE0, then R7/R8 masking
    step();
    setLine(1'b0, 2'b00);
    repeat (SE0MIN) step();
    setLine(1'b1, 2'b01);
    step();
    chk(eoRsmFlag == expEor(SE0MIN), "R6", eoRsmFlag, 1);
    wr(2'd2, 8'h00);
    chk(upRsmFlag && eoRsmFlag, "R7", {upRsmFlag, eoRsmFlag}, 3);
    wr(2'd2, 8'h01);
    chk(!upRsmFlag && eoRsmFlag, "R7", {upRsmFlag, eoRsmFlag}, 1);
    wr(2'd3, 8'h01);
    chk(irq == 1'b0, "R8", irq, 0);
    wr(2'd3, 8'h02);
    chk(irq == 1'b1, "R8", irq, 1);
    wr(2'd2, 8'h02);
    chk(!eoRsmFlag && !irq, "R7", {eoRsmFlag, irq}, 0);
    wr(2'd3, 8'h03);

    // random scenarios
    for (int it = 0; it < 14; it++) begin
      int dur, pre, glitch, cnt, h, m;
      dur    = $urandom % 5;
      pre    = $urandom % (NIDLE - 2);
      glitch = $urandom % 2;
      m      = SE0MIN - 1 + ($urandom % 3);
      wr(2'd1, 8'(dur));
      setLine(1'b0, 2'b10);
      suspendDet = 1'b1; step(); suspendDet = 1'b0;
      setLine(1'b1, 2'b01);
      cnt = 0;
      repeat (pre) begin step(); cnt++; end
      wr(2'd0, 8'h01); cnt++;
      chk(wakeReq && !driveK, "R1", {wakeReq, driveK}, 2);
      if (glitch != 0) begin
        setLine(1'b1, 2'b10); step();
        setLine(1'b1, 2'b01); cnt = 0;
      end
      while (!driveK && cnt < 1000) begin step(); cnt++; end
      chk(cnt == NIDLE + 1, "R3", cnt, NIDLE + 1);
      chk(upRsmFlag && !suspended, "R5", {upRsmFlag, suspended}, 2);
      setLine(1'b0, 2'b10);
      h = 0;
      while (driveK && h < 1000) begin
        if (!wakeReq) h = 2000;
        step(); h++;
      end
      chk(h == expLen(dur), "R4", h, expLen(dur));
      chk(wakeReq == 1'b0, "R4", wakeReq, 0);
      wr(2'd2, 8'h01);
      chk(upRsmFlag == 1'b0, "R7", upRsmFlag, 0);
      repeat (1 + $urandom % 3) step();
      setLine(1'b0, 2'b00);
      repeat (m) step();
      setLine(1'b1, 2'b01);
      step();
      chk(eoRsmFlag == expEor(m), "R6", eoRsmFlag, int'(expEor(m)));
      chk(irq == expEor(m), "R8", irq, int'(expEor(m)));
      wr(2'd2, 8'h02);
      chk(eoRsmFlag == 1'b0, "R7", eoRsmFlag, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule